// File: doc/BRIEF.md
# Fixed-Constant Adder

This block adds a constant, chosen when the design is elaborated, to a variable operand of parameterised width. It returns the sum, truncated to the operand width, and the carry out of the top position. It has no clock and no state. The result settles through a single carry chain.

The constant decides the structure of each bit position. Low positions where the constant holds zero have no carry coming in, so they pass the operand bit straight to the sum. From the lowest set bit of the constant upward, each position holds one small cell:

- A position whose constant bit is 0 uses a plain half adder. It adds the operand bit and the incoming carry.
- A position whose constant bit is 1 uses a modified half adder. It adds the operand bit, the incoming carry and one.

With a constant of one, the block is an incrementer. With a constant of all ones, it is a decrementer, and the carry out then flags a nonzero operand.

Top module: `const_adder`

## Requirements
- R1: For every operand value x, `sum` equals (x + ADDEND) modulo 2^WIDTH.
- R2: If the constant's lowest z bits are all zero, sum bits 0 to z-1 equal operand bits 0 to z-1 for every operand.
- R3: At a position i at or above the lowest set constant bit, where constant bit i is 0, sum bit i equals x[i] XOR carry-in(i). Here carry-in(i) is the carry out of adding the low i bits of x and of the constant.
- R4: At a position i at or above the lowest set constant bit, where constant bit i is 1, sum bit i equals NOT (x[i] XOR carry-in(i)). The carry that leaves position i is x[i] OR carry-in(i).
- R5: With ADDEND = 0, `sum` equals x and `cout` is 0 for every operand.
- R6: With ADDEND = 1, `sum` is x + 1 modulo 2^WIDTH, and `cout` is 1 only when x is all ones.
- R7: With ADDEND all ones, `sum` is x - 1 modulo 2^WIDTH, and `cout` is 1 exactly when x is nonzero.
- R8: `cout` is 1 exactly when x + ADDEND is at least 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | Variable operand |
| sum | output | WIDTH | Low WIDTH bits of x plus the constant |
| cout | output | 1 | Carry out of the most significant position |

## Verification
The bound checker is re-evaluated whenever the operand changes. Against the operand, it checks the following:

- the full sum (R1);
- pass-through of the low zero positions (R2);
- the carry-out rule (R8);
- the special-constant behaviours that apply to the instance being checked (R5, R6, R7).

The checker does not look at the cells one by one. The bench covers them instead: it sweeps all 256 operands at eight bits on five constants, and it predicts each sum bit from the carry of the lower slice (R3, R4). Only these scenarios show that every cell kind is used at the right positions, and that the incrementer and decrementer wrap at the right operand values.

// File: rtl/const_add_pkg.sv
package const_add_pkg;

    typedef enum logic [1:0] {
        CELL_PASS = 2'd0,
        CELL_HA   = 2'd1,
        CELL_MHA  = 2'd2
    } cell_kind_e;

    // number of zero bits below the lowest set bit, capped at w
    function automatic int unsigned low_zero_run(input logic [63:0] v, input int unsigned w);
        int unsigned n;
        bit          hit;
        n   = 0;
        hit = 1'b0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < w && !hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1;
            end
        end
        return n;
    endfunction

    function automatic cell_kind_e kind_at(input logic [63:0] v, input int unsigned pos,
                                           input int unsigned run);
        if (pos < run)  return CELL_PASS;
        if (v[pos])     return CELL_MHA;
        return CELL_HA;
    endfunction

endpackage

// File: rtl/ha_cell.sv
module ha_cell (
    input  logic a_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    typedef struct packed {
        logic s;
        logic c;
    } ha_out_t;

    ha_out_t out_d;

    always_comb begin
        out_d.s = a_i ^ c_i;
        out_d.c = a_i & c_i;
    end

    assign s_o = out_d.s;
    assign c_o = out_d.c;
endmodule

// File: rtl/mha_cell.sv
module mha_cell (
    input  logic a_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    typedef struct packed {
        logic s;
        logic c;
    } mha_out_t;

    mha_out_t out_d;

    // a + c + 1: the sum bit is inverted and the carry is an OR
    always_comb begin
        out_d.s = ~(a_i ^ c_i);
        out_d.c = a_i | c_i;
    end

    assign s_o = out_d.s;
    assign c_o = out_d.c;
endmodule

// File: rtl/const_adder.sv
module const_adder #(
    parameter int unsigned       WIDTH  = 8,
    parameter logic [WIDTH-1:0]  ADDEND = WIDTH'(44)
) (
    input  logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import const_add_pkg::*;

    localparam int unsigned ZRUN = low_zero_run(64'(ADDEND), WIDTH);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_d;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam cell_kind_e KIND = kind_at(64'(ADDEND), i, ZRUN);
        if (KIND == CELL_PASS) begin : g_pass
            assign sum_d[i]   = x[i];
            assign carry[i+1] = 1'b0;
        end else if (KIND == CELL_MHA) begin : g_mha
            mha_cell u_cell (
                .a_i (x[i]),
                .c_i (carry[i]),
                .s_o (sum_d[i]),
                .c_o (carry[i+1])
            );
        end else begin : g_ha
            ha_cell u_cell (
                .a_i (x[i]),
                .c_i (carry[i]),
                .s_o (sum_d[i]),
                .c_o (carry[i+1])
            );
        end
    end

    assign sum  = sum_d;
    assign cout = carry[WIDTH];
endmodule

// File: rtl/const_adder_chk.sv
module const_adder_chk #(
    parameter int unsigned       WIDTH  = 8,
    parameter logic [WIDTH-1:0]  ADDEND = WIDTH'(44)
) (
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    import const_add_pkg::*;

    localparam int unsigned ZRUN = low_zero_run(64'(ADDEND), WIDTH);
    localparam logic [WIDTH:0] TOP = {1'b1, {WIDTH{1'b0}}};

    logic [WIDTH:0] wide_ref;
    logic           over_ref;
    logic [WIDTH:0] wide_res;

    always_comb begin
        wide_ref = {1'b0, x} + {1'b0, ADDEND};
        over_ref = (ADDEND != '0) && ({1'b0, x} >= (TOP - {1'b0, ADDEND}));
        wide_res = {cout, sum};
    end

    always_comb begin
        // R1
        sum_match_chk: assert (sum == wide_ref[WIDTH-1:0]);
        // R8
        carry_limit_chk: assert (cout == over_ref);
        // R2
        for (int unsigned i = 0; i < WIDTH; i++) begin
            if (i < ZRUN) begin
                low_pass_chk: assert (sum[i] == x[i]);
            end
        end
        // R5
        if (ADDEND == '0) begin
            zero_add_chk: assert (wide_res == {1'b0, x});
        end
        // R6
        if (ADDEND == WIDTH'(1)) begin
            inc_wrap_chk: assert (cout == (x == '1));
        end
        // R7
        if (ADDEND == '1) begin
            dec_flag_chk: assert (cout == (x != '0));
        end
    end
endmodule

bind const_adder const_adder_chk #(.WIDTH(WIDTH), .ADDEND(ADDEND)) u_chk (
    .x    (x),
    .sum  (sum),
    .cout (cout)
);

// File: tb/const_adder_test.sv
module const_adder_test;
    localparam int W = 8;
    localparam int NI = 5;
    localparam logic [W-1:0] KV [NI] = '{8'h2C, 8'h00, 8'h01, 8'hFF, 8'hA5};

    logic         clk;
    logic         rst_n;
    logic [W-1:0] x;
    logic [W-1:0] s_arr [NI];
    logic         c_arr [NI];
    int           n_vec;
    int           n_bad;
    bit           done;

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    const_adder #(.WIDTH(W), .ADDEND(8'h2C)) uut    (.x(x), .sum(s_arr[0]), .cout(c_arr[0]));
    const_adder #(.WIDTH(W), .ADDEND(8'h00)) u_zero (.x(x), .sum(s_arr[1]), .cout(c_arr[1]));
    const_adder #(.WIDTH(W), .ADDEND(8'h01)) u_inc  (.x(x), .sum(s_arr[2]), .cout(c_arr[2]));
    const_adder #(.WIDTH(W), .ADDEND(8'hFF)) u_dec  (.x(x), .sum(s_arr[3]), .cout(c_arr[3]));
    const_adder #(.WIDTH(W), .ADDEND(8'hA5)) u_mix  (.x(x), .sum(s_arr[4]), .cout(c_arr[4]));

    task automatic compare(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s x=%0h actual=%0h expected=%0h", req, x, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] v);
        @(posedge clk);
        x = v;
        @(negedge clk);
    endtask

    task automatic check_reset();
        apply('0);
        compare("R1 reset", int'(s_arr[0]), 8'h2C);
        compare("R8 reset", int'(c_arr[0]), 0);
    endtask

    task automatic sweep_full(input int k, input string tag);
        for (int v = 0; v < 256; v++) begin
            int wide;
            apply(W'(v));
            wide = v + int'(KV[k]);
            compare({"R1 ", tag}, int'(s_arr[k]), wide % 256);
            compare({"R8 ", tag}, int'(c_arr[k]), wide / 256);
        end
    endtask

    task automatic sweep_low_pass();
        // uut constant 0x2C: two low zeros; u_zero: all eight pass
        for (int v = 0; v < 256; v++) begin
            apply(W'(v));
            compare("R2 low2", int'(s_arr[0][1:0]), v % 4);
            compare("R5 sum", int'(s_arr[1]), v);
            compare("R5 cout", int'(c_arr[1]), 0);
        end
    endtask

    task automatic sweep_inc();
        for (int v = 0; v < 256; v++) begin
            apply(W'(v));
            compare("R6 sum", int'(s_arr[2]), (v + 1) % 256);
            compare("R6 cout", int'(c_arr[2]), (v == 255) ? 1 : 0);
        end
    endtask

    task automatic sweep_dec();
        for (int v = 0; v < 256; v++) begin
            apply(W'(v));
            compare("R7 sum", int'(s_arr[3]), (v + 255) % 256);
            compare("R7 cout", int'(c_arr[3]), (v != 0) ? 1 : 0);
        end
    endtask

    task automatic sweep_cells(input int k);
        int lo;
        int cin;
        int xb;
        int kb;
        for (int v = 0; v < 256; v++) begin
            apply(W'(v));
            lo = 0;
            for (int i = 0; i < 8; i++) begin
                if (KV[k][i]) begin
                    lo = i;
                    break;
                end
            end
            for (int i = lo; i < 8; i++) begin
                cin = ((v % (1 << i)) + (int'(KV[k]) % (1 << i))) >> i;
                xb  = (v >> i) & 1;
                kb  = int'(KV[k][i]);
                if (kb == 0) compare("R3 bit", int'(s_arr[k][i]), xb ^ cin);
                else         compare("R4 bit", int'(s_arr[k][i]), 1 - (xb ^ cin));
            end
        end
    endtask

    initial begin
        n_vec = 0;
        n_bad = 0;
        done  = 1'b0;
        x     = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        check_reset();
        for (int k = 0; k < NI; k++) sweep_full(k, $sformatf("k=%0h", KV[k]));
        sweep_low_pass();
        sweep_inc();
        sweep_dec();
        sweep_cells(0);
        sweep_cells(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule